// File: doc/BRIEF.md
# GPIO Bank with Pin Interrupts

A 32-pin general-purpose I/O bank controlled through a small memory-mapped port. Software sets the value driven on each pin and whether the pin is driven at all. It can also read a synchronized sample of the pin levels. Every pin can raise an interrupt. Each pin has a detect-select bit, an enable bit, a trigger mode bit (level or edge) and a polarity bit. Detected events latch into a sticky status register. All status bits whose enable is set are ORed into one bank interrupt line.

Every writable register has three write views: a plain write, a set view that ORs the mask into the register, and a clear view that removes the masked bits. Software can change single pins without a read-modify-write. Status bits ignore plain and set writes, so they can only be retired through the clear view. The bus takes a write in one cycle. A read returns its data one cycle after the request, flagged by a valid pulse.

Top module: `gpio_bank`

## Requirements
- R1: After synchronous reset, every register reads 0, `pin_oe` and `pin_out` are 0, and `irq` is 0.
- R2: Address bits [6:4] select the register: 0 output data, 1 input sample, 2 output enable, 3 detect select, 4 interrupt enable, 5 trigger mode, 6 polarity, 7 status. Address bits [3:0] select the access kind: 0x0 plain write, 0x4 set, 0x8 clear. A write with 0xC in bits [3:0] changes nothing. A read at any of the four offsets returns the register's value. That value appears on `bus_rdata` in the cycle after `bus_re`, with `bus_rvalid` high for exactly that cycle.
- R3: A set-view write ORs `bus_wdata` into the register. A clear-view write clears every bit that is 1 in `bus_wdata`.
- R4: `pin_out` equals the output data register. `pin_oe` equals the output enable register, where 1 means driven and 0 means high impedance.
- R5: `pin_in` passes through two synchronizing flops, so a pin change is readable in register 1 two cycles after it is applied. Writes to register 1 are ignored.
- R6: With trigger mode bit 0 (edge), a polarity bit of 1 latches status on a synchronized rising edge and 0 on a falling edge. Status is set one cycle after the synchronized sample changes.
- R7: With trigger mode bit 1 (level), a polarity bit of 1 means active high and 0 means active low. Status sets again on every cycle in which the active level persists.
- R8: A pin whose detect-select bit is 0 never sets its status bit.
- R9: Status bits can only be cleared through the clear view. Plain and set writes to register 7 have no effect. When a detect event and a clear hit the same bit in the same cycle, the bit stays set.
- R10: `irq` is high exactly when some status bit and its interrupt enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Register index [6:4] and access kind [3:0] |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read request |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Value to drive on each pin |
| pin_oe | output | 32 | Per-pin drive enable |
| irq | output | 1 | Bank interrupt |

## Verification
A corrupted control register shows on `pin_out` or `pin_oe` in the cycle after the write, or through a read one cycle after the request. A wrong synchronizer depth or a wrong edge history moves the first `irq` assertion or the status read-back by a cycle, or makes it appear for the wrong polarity. A status bit that clears when it should not, or sticks when it should not, shows on `irq` at the next edge. The bench mirrors the bank with a cycle model and compares every port on every cycle, so a fault shows within one cycle of the stimulus that exposes it.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
    localparam int GB_PINS   = 32;
    localparam int GB_NREG   = 8;
    localparam int GB_IDX_W  = $clog2(GB_NREG);
    localparam int GB_OP_W   = 4;
    localparam int GB_ADDR_W = GB_IDX_W + GB_OP_W;
    localparam int GB_SYNC   = 2;

    typedef enum logic [GB_IDX_W-1:0] {
        GB_DOUT = 3'd0,
        GB_DIN  = 3'd1,
        GB_DOE  = 3'd2,
        GB_SEL  = 3'd3,
        GB_IEN  = 3'd4,
        GB_LEV  = 3'd5,
        GB_POL  = 3'd6,
        GB_STAT = 3'd7
    } gb_reg_e;

    typedef enum logic [GB_OP_W-1:0] {
        GB_OP_WR   = 4'h0,
        GB_OP_SET  = 4'h4,
        GB_OP_CLR  = 4'h8,
        GB_OP_NONE = 4'hC
    } gb_op_e;

    typedef struct packed {
        gb_reg_e idx;
        gb_op_e  op;
    } gb_addr_t;

    function automatic logic gb_is_writable(int r);
        return (r != int'(GB_DIN)) && (r != int'(GB_STAT));
    endfunction
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [STAGES-1:0][N-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
`timescale 1ns/1ps
module gpio_ctrl_regs
    import gpio_bank_pkg::*;
#(
    parameter int N = GB_PINS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  gb_addr_t                   wr_addr,
    input  logic [N-1:0]               wr_data,
    output logic [GB_NREG-1:0][N-1:0]  regs_q,
    output logic [N-1:0]               stat_clr
);
    for (genvar r = 0; r < GB_NREG; r++) begin : g_reg
        if (!gb_is_writable(r)) begin : g_ro
            assign regs_q[r] = '0;
        end else begin : g_rw
            logic [N-1:0] q;
            logic         hit;
            assign hit = wr_en && (wr_addr.idx == gb_reg_e'(r));
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (hit) begin
                    case (wr_addr.op)
                        GB_OP_WR:  q <= wr_data;
                        GB_OP_SET: q <= q | wr_data;
                        GB_OP_CLR: q <= q & ~wr_data;
                        default:   q <= q;
                    endcase
                end
            end
            assign regs_q[r] = q;
        end
    end

    assign stat_clr = (wr_en && wr_addr.idx == GB_STAT && wr_addr.op == GB_OP_CLR)
                      ? wr_data : '0;

    AST_SET_ALIAS_ORS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr.idx == GB_IEN && wr_addr.op == GB_OP_SET)
        |=> ((regs_q[GB_IEN] & $past(wr_data)) == $past(wr_data))); // R3
    AST_CLR_ALIAS_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr.idx == GB_DOUT && wr_addr.op == GB_OP_CLR)
        |=> ((regs_q[GB_DOUT] & $past(wr_data)) == '0)); // R3
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    input  logic [N-1:0] sel,
    input  logic [N-1:0] lev,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] clr,
    output logic [N-1:0] stat_q
);
    logic [N-1:0] prev_q;
    logic [N-1:0] evt;

    for (genvar p = 0; p < N; p++) begin : g_pin
        logic rise, fall, active;
        assign rise   = din[p] & ~prev_q[p];
        assign fall   = ~din[p] & prev_q[p];
        assign active = (din[p] == pol[p]);
        assign evt[p] = sel[p] & (lev[p] ? active : (pol[p] ? rise : fall));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            stat_q <= '0;
        end else begin
            prev_q <= din;
            stat_q <= (stat_q & ~clr) | evt;
        end
    end

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (rst)
        (($past(evt) & ~stat_q) == '0)); // R6
    AST_CLEAR_ONLY_BY_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (($past(stat_q) & ~stat_q & ~$past(clr)) == '0)); // R9
    AST_UNSELECTED_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & ~$past(stat_q) & ~$past(sel)) == '0)); // R8
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int N = GB_PINS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [GB_ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]         bus_wdata,
    input  logic                 bus_we,
    input  logic                 bus_re,
    output logic [N-1:0]         bus_rdata,
    output logic                 bus_rvalid,
    input  logic [N-1:0]         pin_in,
    output logic [N-1:0]         pin_out,
    output logic [N-1:0]         pin_oe,
    output logic                 irq
);
    gb_addr_t                   acc;
    logic [GB_NREG-1:0][N-1:0]  regs_q;
    logic [N-1:0]               stat_clr;
    logic [N-1:0]               din;
    logic [N-1:0]               stat_q;

    assign acc = gb_addr_t'(bus_addr);

    gpio_sync #(.N(N), .STAGES(GB_SYNC)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(din)
    );

    gpio_ctrl_regs #(.N(N)) u_regs (
        .clk(clk), .rst(rst), .wr_en(bus_we), .wr_addr(acc),
        .wr_data(bus_wdata), .regs_q(regs_q), .stat_clr(stat_clr)
    );

    gpio_irq_detect #(.N(N)) u_detect (
        .clk(clk), .rst(rst), .din(din),
        .sel(regs_q[GB_SEL]), .lev(regs_q[GB_LEV]), .pol(regs_q[GB_POL]),
        .clr(stat_clr), .stat_q(stat_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_re;
            if (bus_re) begin
                case (acc.idx)
                    GB_DIN:  bus_rdata <= din;
                    GB_STAT: bus_rdata <= stat_q;
                    default: bus_rdata <= regs_q[acc.idx];
                endcase
            end
        end
    end

    assign pin_out = regs_q[GB_DOUT];
    assign pin_oe  = regs_q[GB_DOE];
    assign irq     = |(stat_q & regs_q[GB_IEN]);

    AST_READ_ACK: assert property (@(posedge clk) disable iff (rst)
        bus_re |=> bus_rvalid); // R2
    AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> !bus_rvalid); // R2
endmodule

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;
    import gpio_bank_pkg::*;
    localparam int N  = GB_PINS;
    localparam int AW = GB_ADDR_W;

    logic clk = 1'b0;
    logic rst;
    logic [AW-1:0] bus_addr;
    logic [N-1:0]  bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;
    logic bus_we, bus_re, bus_rvalid, irq;

    always #10 clk = ~clk;

    gpio_bank dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [N-1:0] pins_now = '0;

    logic [N-1:0] m_dout, m_doe, m_sel, m_ien, m_lev, m_pol, m_stat;
    logic [N-1:0] m_s1, m_din, m_prev, m_rdata;
    logic         m_rvalid;

    task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [N-1:0] m_read(input logic [2:0] idx);
        case (idx)
            3'd0: return m_dout;
            3'd1: return m_din;
            3'd2: return m_doe;
            3'd3: return m_sel;
            3'd4: return m_ien;
            3'd5: return m_lev;
            3'd6: return m_pol;
            default: return m_stat;
        endcase
    endfunction

    function automatic logic [N-1:0] merge(input logic [N-1:0] old, input logic [N-1:0] wd,
                                           input logic [3:0] op);
        case (op)
            4'h0: return wd;
            4'h4: return old | wd;
            4'h8: return old & ~wd;
            default: return old;
        endcase
    endfunction

    task automatic cycle(input logic we, input logic re, input logic [AW-1:0] a,
                         input logic [N-1:0] wd, input logic [N-1:0] pins);
        logic [N-1:0] evt, clr, rd_n;
        logic [2:0] idx;
        logic [3:0] op;
        @(negedge clk);
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = wd; pin_in = pins;
        idx = a[6:4];
        op  = a[3:0];
        evt = m_sel & ((m_lev & ~(m_din ^ m_pol)) |
                       (~m_lev & m_pol & m_din & ~m_prev) |
                       (~m_lev & ~m_pol & ~m_din & m_prev));
        clr  = (we && idx == 3'd7 && op == 4'h8) ? wd : '0;
        rd_n = m_read(idx);
        @(posedge clk);
        if (we) begin
            case (idx)
                3'd0: m_dout = merge(m_dout, wd, op);
                3'd2: m_doe  = merge(m_doe, wd, op);
                3'd3: m_sel  = merge(m_sel, wd, op);
                3'd4: m_ien  = merge(m_ien, wd, op);
                3'd5: m_lev  = merge(m_lev, wd, op);
                3'd6: m_pol  = merge(m_pol, wd, op);
                default: ;
            endcase
        end
        m_stat   = (m_stat & ~clr) | evt;
        m_prev   = m_din;
        m_din    = m_s1;
        m_s1     = pins;
        m_rvalid = re;
        if (re) m_rdata = rd_n;
        #5;
        chk("R4 pin_out", pin_out, m_dout);
        chk("R4 pin_oe", pin_oe, m_doe);
        chk("R10 irq", {31'd0, irq}, {31'd0, |(m_stat & m_ien)});
        chk("R2 rvalid", {31'd0, bus_rvalid}, {31'd0, m_rvalid});
        if (m_rvalid) chk("R2 rdata", bus_rdata, m_rdata);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] wd);
        cycle(1'b1, 1'b0, a, wd, pins_now);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, '0, '0, pins_now);
    endtask

    task automatic rd_exp(input logic [AW-1:0] a, input logic [N-1:0] exp, input string tag);
        cycle(1'b0, 1'b1, a, '0, pins_now);
        chk(tag, bus_rdata, exp);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] r;
        rst = 1'b1; bus_we = 0; bus_re = 0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
        {m_dout, m_doe, m_sel, m_ien, m_lev, m_pol, m_stat} = '0;
        {m_s1, m_din, m_prev, m_rdata} = '0;
        m_rvalid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1 pin_oe", pin_oe, '0);
        chk("R1 pin_out", pin_out, '0);
        chk("R1 irq", {31'd0, irq}, '0);
        for (int i = 0; i < 8; i++) rd_exp(AW'(i * 16), '0, "R1 reg read");

        // R2 / R3 / R4: write views
        wr(7'h00, 32'hA5A5_0F0F);
        rd_exp(7'h00, 32'hA5A5_0F0F, "R2 plain write");
        rd_exp(7'h04, 32'hA5A5_0F0F, "R2 alias read");
        wr(7'h04, 32'h0000_F000);
        chk("R3 set view", pin_out, 32'hA5A5_FF0F);
        wr(7'h08, 32'hA500_0000);
        chk("R3 clear view", pin_out, 32'h00A5_FF0F);
        wr(7'h0C, 32'hFFFF_FFFF);
        chk("R2 offset C ignored", pin_out, 32'h00A5_FF0F);
        wr(7'h20, 32'hFFFF_0000);
        chk("R4 drive enable", pin_oe, 32'hFFFF_0000);

        // R5: synchronizer depth and read-only input sample
        pins_now = 32'h1234_5678;
        idle(2);
        rd_exp(7'h10, 32'h1234_5678, "R5 sample after two");
        pins_now = 32'h0000_0000;
        idle(1);
        rd_exp(7'h10, 32'h1234_5678, "R5 not yet visible");
        idle(1);
        rd_exp(7'h10, 32'h0000_0000, "R5 sample updated");
        wr(7'h10, 32'hFFFF_FFFF);
        rd_exp(7'h10, 32'h0000_0000, "R5 write ignored");

        // R6: edge detection on pin 3
        wr(7'h30, 32'hFFFF_FFFF);
        wr(7'h60, 32'h0000_0008);
        wr(7'h40, 32'h0000_0008);
        pins_now = 32'h0000_0008;
        idle(2);
        chk("R6 no irq before sync", {31'd0, irq}, '0);
        idle(1);
        chk("R6 irq on rise", {31'd0, irq}, 32'd1);
        rd_exp(7'h70, 32'h0000_0008, "R6 status set");
        wr(7'h78, 32'h0000_0008);
        rd_exp(7'h70, 32'h0000_0000, "R6 status cleared");
        pins_now = 32'h0;
        idle(4);
        rd_exp(7'h70, 32'h0000_0000, "R6 fall ignored when rising");

        // R9: plain and set writes leave status alone
        wr(7'h70, 32'hFFFF_FFFF);
        wr(7'h74, 32'hFFFF_FFFF);
        rd_exp(7'h70, 32'h0000_0000, "R9 status not writable");

        // R7 / R9: level mode, detect wins over clear
        wr(7'h64, 32'h0000_0010);
        wr(7'h54, 32'h0000_0010);
        wr(7'h44, 32'h0000_0010);
        pins_now = 32'h0000_0010;
        idle(3);
        wr(7'h78, 32'h0000_0010);
        rd_exp(7'h70, 32'h0000_0010, "R7 level persists over clear");
        chk("R9 detect wins", {31'd0, irq}, 32'd1);
        pins_now = 32'h0;
        idle(3);
        rd_exp(7'h70, 32'h0000_0010, "R7 sticky after release");
        wr(7'h78, 32'h0000_0010);
        rd_exp(7'h70, 32'h0000_0000, "R7 cleared when inactive");

        // R8: unselected pin never sets status
        wr(7'h38, 32'h0000_0020);
        wr(7'h64, 32'h0000_0020);
        pins_now = 32'h0000_0020;
        idle(3);
        rd_exp(7'h70, 32'h0000_0000, "R8 unselected quiet");
        pins_now = 32'h0;
        idle(3);

        // R10: enable gates the interrupt line
        wr(7'h64, 32'h0000_0040);
        pins_now = 32'h0000_0040;
        idle(3);
        chk("R10 masked", {31'd0, irq}, '0);
        rd_exp(7'h70, 32'h0000_0040, "R10 status pending");
        wr(7'h44, 32'h0000_0040);
        chk("R10 unmasked", {31'd0, irq}, 32'd1);
        wr(7'h78, 32'h0000_0040);
        chk("R10 cleared", {31'd0, irq}, '0);
        pins_now = 32'h0;
        idle(3);

        // constrained random traffic
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] opsel;
            logic [3:0] op;
            r = $urandom();
            if (r[2:0] == 3'd0) pins_now = $urandom();
            opsel = r[5:4];
            op = {opsel, 2'b00};
            cycle(r[8] & r[9], r[10], {r[14:12], op}, $urandom(), pins_now);
        end

        summary();
        $finish;
    end
endmodule